// File: doc/BRIEF.md
# Ring Hard-Sync Controller for Three Phase Accumulators

This block decides, every clock, which of three phase-accumulator oscillators must have its accumulator forced to zero by hard sync. The oscillators form a ring: oscillator 2 drives oscillator 0, oscillator 0 drives oscillator 1, and oscillator 1 drives oscillator 2. Each oscillator gives the block the most significant bit (bit 23) of the sum it is about to load this cycle, along with its sync-enable and test bits. The block returns one clear strobe per oscillator, which overrides that oscillator's new sum on the same clock edge.

All three oscillators are treated as if they advance at the same instant. The block detects the upward transition of each accumulator's top bit against the value that oscillator actually committed last cycle. It then resolves every clear from those post-advance values, so the order in which the oscillators are evaluated has no effect. A source that is being synced itself in the same cycle that its top bit rises does not sync its own destination. The block also keeps a shadow of each committed top bit and exports it to the destination as the ring-modulation bit.

Top module: `osc_sync_ctrl`

## Requirements
- R1: A rise of oscillator k is an edge where the committed top bit of k was 0 and `next_msb_i[k]` is 1. Only a rise can cause a clear.
- R2: `clr_o[d]` is 1 in the cycle in which the source of d rises while `sync_en_i[d]` is 1. The ring order is source(0)=2, source(1)=0 and source(2)=1.
- R3: `clr_o[d]` stays 0 whenever `sync_en_i[d]` is 0, even if its source rises.
- R4: `clr_o[d]` stays 0 when its source s rises in a cycle where `sync_en_i[s]` is 1 and the source of s also rises.
- R5: An oscillator whose `test_i` bit is 1 has no rise, and its committed top bit becomes 0 at the next edge.
- R6: `ring_msb_o[d]` equals the committed top bit of the source of d, as bit d of the output vector.
- R7: An oscillator that is cleared has a committed top bit of 0 after that edge. If it presents a top bit of 1 in the next cycle, that counts as a new rise.
- R8: While `rst_ni` is 0, every committed top bit is 0, so `ring_msb_o` is 0.
- R9: A top bit that stays 1 across consecutive cycles causes no further rise.
- R10: If all three oscillators rise together with every sync enable set, no clear is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| next_msb_i | input | NUM_OSC | Bit 23 of each oscillator's post-advance sum for this cycle |
| sync_en_i | input | NUM_OSC | Hard-sync enable of each destination oscillator |
| test_i | input | NUM_OSC | Test bit per oscillator; the accumulator is held at zero |
| clr_o | output | NUM_OSC | Per-oscillator strobe that zeroes the accumulator at this edge |
| ring_msb_o | output | NUM_OSC | Committed top bit of each oscillator's source, used for ring modulation |

## Verification
The hardest case to reach is the chained exception. It needs two neighbouring oscillators to cross their top bit in the same cycle while the middle one has sync enabled. The stimulus first parks every committed top bit at 0, then raises two or three inputs together with chosen enables. A further sequence clears an oscillator while its input stays high, and then holds that input high for one more cycle. This shows that a clear restarts edge detection, and that a top bit held high does not retrigger a rise.

// File: rtl/osc_sync_pkg.sv
package osc_sync_pkg;
  localparam int unsigned DEF_NUM_OSC = 3;

  // ring topology: oscillator k is driven by oscillator k-1 (mod n)
  function automatic int unsigned src_of(input int unsigned k, input int unsigned n);
    return (k + n - 1) % n;
  endfunction
endpackage

// File: rtl/osc_msb_edge.sv
module osc_msb_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic next_msb_i,
  input  logic test_i,
  input  logic clr_i,
  output logic rise_o,
  output logic msb_q_o
);
  logic msb_q;

  assign rise_o  = ~msb_q & next_msb_i & ~test_i;
  assign msb_q_o = msb_q;

  // shadow of the committed top bit; sync clear and test both force zero
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               msb_q <= 1'b0;
    else if (clr_i || test_i)  msb_q <= 1'b0;
    else                       msb_q <= next_msb_i;
  end

  p_test_no_rise_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    test_i |-> !rise_o);
  p_single_rise_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_o && !clr_i) |=> !rise_o);
  p_cleared_low_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !msb_q_o);
endmodule

// File: rtl/osc_sync_resolve.sv
module osc_sync_resolve
  import osc_sync_pkg::*;
#(
  parameter int unsigned NUM_OSC = DEF_NUM_OSC
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_OSC-1:0] rise_i,
  input  logic [NUM_OSC-1:0] sync_en_i,
  output logic [NUM_OSC-1:0] clr_o
);
  for (genvar d = 0; d < NUM_OSC; d++) begin : g_dst
    localparam int unsigned S  = src_of(d, NUM_OSC);
    localparam int unsigned SS = src_of(S, NUM_OSC);
    logic src_synced;

    // a source reset in this very cycle does not pass its edge on
    assign src_synced = sync_en_i[S] & rise_i[SS];
    assign clr_o[d]   = rise_i[S] & sync_en_i[d] & ~src_synced;

    p_clear_needs_sync_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_o[d] |-> (sync_en_i[d] && rise_i[S]));
    p_chain_block_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rise_i[S] && sync_en_i[S] && rise_i[SS]) |-> !clr_o[d]);
  end
endmodule

// File: rtl/osc_sync_ctrl.sv
module osc_sync_ctrl
  import osc_sync_pkg::*;
#(
  parameter int unsigned NUM_OSC = DEF_NUM_OSC
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_OSC-1:0] next_msb_i,
  input  logic [NUM_OSC-1:0] sync_en_i,
  input  logic [NUM_OSC-1:0] test_i,
  output logic [NUM_OSC-1:0] clr_o,
  output logic [NUM_OSC-1:0] ring_msb_o
);
  logic [NUM_OSC-1:0] rise;
  logic [NUM_OSC-1:0] msb_q;

  for (genvar k = 0; k < NUM_OSC; k++) begin : g_osc
    osc_msb_edge u_edge (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .next_msb_i (next_msb_i[k]),
      .test_i     (test_i[k]),
      .clr_i      (clr_o[k]),
      .rise_o     (rise[k]),
      .msb_q_o    (msb_q[k])
    );
    assign ring_msb_o[k] = msb_q[src_of(k, NUM_OSC)];

    p_ring_after_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_o[src_of(k, NUM_OSC)] |=> !ring_msb_o[k]);
  end

  osc_sync_resolve #(.NUM_OSC(NUM_OSC)) u_resolve (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rise_i    (rise),
    .sync_en_i (sync_en_i),
    .clr_o     (clr_o)
  );

  p_all_rise_no_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&rise && &sync_en_i) |-> (clr_o == '0));

  always_comb begin
    if (!rst_ni) p_reset_ring_r8: assert (ring_msb_o == '0);
  end
endmodule

// File: tb/osc_sync_ctrl_tb.sv
module osc_sync_ctrl_tb_top;
  localparam int N = 3;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [N-1:0] nm = '0, sy = '0, ts = '0;
  logic [N-1:0] clr, ring;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  typedef struct { logic [N-1:0] clr; logic [N-1:0] ring; string tag; } item_t;
  item_t sb[$];

  logic [N-1:0] m = '0;  // bench's own view of committed top bits

  always #10 clk = ~clk;

  osc_sync_ctrl #(.NUM_OSC(N)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .next_msb_i(nm), .sync_en_i(sy),
    .test_i(ts), .clr_o(clr), .ring_msb_o(ring)
  );

  function automatic int src(int k); return (k + N - 1) % N; endfunction

  task automatic chk(string tag, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%b exp=%b", tag, act, exp);
    end
  endtask

  task automatic drive(logic [N-1:0] n, logic [N-1:0] s, logic [N-1:0] t, string tag);
    logic [N-1:0] r, c, g;
    @(negedge clk);
    nm = n; sy = s; ts = t;
    for (int k = 0; k < N; k++) r[k] = !m[k] && n[k] && !t[k];
    for (int d = 0; d < N; d++) begin
      c[d] = r[src(d)] && s[d] && !(s[src(d)] && r[src(src(d))]);
      g[d] = m[src(d)];
    end
    sb.push_back('{clr: c, ring: g, tag: tag});
    for (int k = 0; k < N; k++) m[k] = (c[k] || t[k]) ? 1'b0 : n[k];
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      @(negedge clk);
      #8;
      if (sb.size() > 0) begin
        it = sb.pop_front();
        chk({it.tag, " clr"}, clr, it.clr);
        chk({it.tag, " ring"}, ring, it.ring);
      end
    end
  end

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog act=hung exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    nm = '1;
    repeat (2) @(negedge clk);
    #5 chk("R8 reset ring", ring, '0);
    nm = '0;
    @(negedge clk);
    rst_ni = 1'b1;
    drive(3'b000, 3'b111, 3'b000, "R1 idle");
    drive(3'b001, 3'b010, 3'b000, "R2 osc0 syncs osc1");
    drive(3'b001, 3'b010, 3'b000, "R9 held high");
    drive(3'b000, 3'b000, 3'b000, "R6 ring fall");
    drive(3'b100, 3'b000, 3'b000, "R3 no enable");
    drive(3'b000, 3'b001, 3'b000, "R6 settle");
    drive(3'b101, 3'b011, 3'b000, "R4 chain blocked");
    drive(3'b001, 3'b011, 3'b000, "R7 cleared osc0 rises");
    drive(3'b000, 3'b000, 3'b000, "R6 settle2");
    drive(3'b010, 3'b100, 3'b010, "R5 test blocks rise");
    drive(3'b010, 3'b100, 3'b000, "R5 rise after test");
    drive(3'b000, 3'b000, 3'b000, "R6 settle3");
    drive(3'b111, 3'b111, 3'b000, "R10 all rise");
    drive(3'b000, 3'b000, 3'b000, "R6 settle4");
    drive(3'b100, 3'b001, 3'b000, "R2 osc2 syncs osc0");
    drive(3'b100, 3'b001, 3'b000, "R9 hold osc2");
    drive(3'b000, 3'b000, 3'b000, "R6 final");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule